// File: doc/BRIEF.md
# Three-Dimensional DMA Count Sequencer

This block walks a three-dimensional transfer held in one parameter set and turns it into a stream of array-sized requests for a downstream transfer engine. The set holds:

- a source and a destination start address;
- a packed word with the per-array byte count and the number of arrays in a frame;
- a frame count;
- signed array and frame strides, one pair for the source and one for the destination;
- a reload value for the array count;
- a mode bit that selects how much work one synchronization event buys.

Software loads a set with a one-cycle load pulse. Each sync event then releases either a single array (array-synchronized mode) or a whole frame of arrays (frame-synchronized mode). Requests are offered on a valid/ready pair. Each request carries a source address, a destination address and a byte count. After every accepted request the block updates its counts and addresses itself. It pulses a completion flag once the last array of the last frame has been accepted.

The block holds one event while it is serving another. An event beyond that one is reported as missed. An event that finds no live parameter set is also reported as missed. A load whose counts describe an empty transfer leaves the block inactive.

Top module: `dma3d_seq`

## Requirements
- R1: After reset, req_valid, set_active, set_done and evt_missed are all low.
- R2: cfg_count_word carries the arrays-per-frame count in bits 31:16 and the bytes-per-array count in bits 15:0. Every request carries the bytes-per-array count. Counts are used as given, with no minus-one encoding. In frame-synchronized mode the accepted bytes of a set total bytes × arrays × frames.
- R3: With cfg_frame_sync = 0 (array-synchronized), each event produces exactly one request of one array.
- R4: In array-synchronized mode, accepting the last array of a frame decrements the frame count. The count of arrays for the next frame is then taken from cfg_arr_reload, so a set issues arrays + (frames − 1) × reload requests.
- R5: With cfg_frame_sync = 1 (frame-synchronized), each event produces one request per array of the frame, and cfg_arr_reload has no effect.
- R6: Within a frame, each accepted request moves the next request's source by the sign-extended source array stride and its destination by the destination array stride, independently.
- R7: At a frame boundary the frame stride is added to the start address of the last array in array-synchronized mode, and to the start address of the frame in frame-synchronized mode. Source and destination each use their own stride.
- R8: set_done pulses for one cycle, in the cycle after the final request of the set is accepted. set_active is low in that cycle.
- R9: An event that arrives while an event is being served is held (depth one) and is served with no gap after the current event's last request is accepted. An event arriving while one is already held raises evt_missed for one cycle, one cycle later. A held event that remains when the set completes is dropped and flagged the same way.
- R10: An event that arrives with no live set (never loaded, completed, or rejected) raises evt_missed and produces no request.
- R11: A load is rejected, leaving set_active low, if any of the following holds: the byte count is zero, the array count is zero, the frame count is zero, or the block is in array-synchronized mode with more than one frame and a zero reload value.
- R12: While req_valid is high and req_ready is low, the request and its fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the parameter set on the inputs below |
| cfg_src | input | ADDR_W | Source start address |
| cfg_dst | input | ADDR_W | Destination start address |
| cfg_count_word | input | 2*CNT_W | Arrays per frame (upper half), bytes per array (lower half) |
| cfg_frames | input | CNT_W | Frame count |
| cfg_src_aidx | input | IDX_W | Signed source array stride |
| cfg_dst_aidx | input | IDX_W | Signed destination array stride |
| cfg_src_fidx | input | IDX_W | Signed source frame stride |
| cfg_dst_fidx | input | IDX_W | Signed destination frame stride |
| cfg_arr_reload | input | CNT_W | Array count for frames after the first (array-synchronized mode) |
| cfg_frame_sync | input | 1 | 0: one array per event, 1: one frame per event |
| sync_evt | input | 1 | Synchronization event pulse |
| req_ready | input | 1 | Transfer engine accepts the request |
| req_valid | output | 1 | Request offered |
| req_src | output | ADDR_W | Request source address |
| req_dst | output | ADDR_W | Request destination address |
| req_bytes | output | CNT_W | Request byte count |
| set_active | output | 1 | A live parameter set has work left |
| set_done | output | 1 | One-cycle completion pulse |
| evt_missed | output | 1 | One-cycle missed-event pulse |

## Verification
The assertions check the properties that hold cycle by cycle. A stalled request keeps its fields (R12). No request appears without a live set, and completion coincides with an idle, inactive block (R8, R10). A miss is always traceable to an event or to service in the previous cycle. Request counts per event, the reload of the array count, stride arithmetic across frame boundaries, and the depth-one queue with its miss flag (R3–R7, R9) depend on the whole history of a set. Only the bench's reference model and its scenarios show these, under randomized backpressure.

// File: rtl/dma3d_pkg.sv
package dma3d_pkg;

  // Work released by one synchronization event.
  typedef enum logic {
    SYNC_ARRAY = 1'b0,
    SYNC_FRAME = 1'b1
  } sync_mode_e;

  // Pointer lane indexes.
  localparam int PTR_SRC = 0;
  localparam int PTR_DST = 1;
  localparam int NUM_PTR = 2;

endpackage

// File: rtl/dma3d_evq.sv
// Event admission: starts service, holds one event, flags misses.
module dma3d_evq (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic evt,
  input  logic busy,
  input  logic serve_end,
  input  logic live_nxt,
  output logic start,
  output logic missed
);

  logic pend_q, pend_n;
  logic miss_q, miss_n;
  logic slot_free;

  assign slot_free = !busy || serve_end;

  always_comb begin
    start  = 1'b0;
    pend_n = pend_q;
    miss_n = 1'b0;
    if (load) begin
      pend_n = 1'b0;
      miss_n = evt;
    end else if (!live_nxt) begin
      // no work left: anything arriving or held is lost
      pend_n = 1'b0;
      miss_n = evt || pend_q;
    end else if (slot_free) begin
      if (pend_q) begin
        start  = 1'b1;
        pend_n = evt;
      end else if (evt) begin
        start = 1'b1;
      end
    end else if (evt) begin
      if (pend_q) miss_n = 1'b1;
      else        pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      miss_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      miss_q <= miss_n;
    end
  end

  assign missed = miss_q;

endmodule

// File: rtl/dma3d_cnt.sv
// Count tracking: arrays left in the frame, frames left, mode.
module dma3d_cnt
  import dma3d_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] cfg_arrays,
  input  logic [CNT_W-1:0] cfg_bytes,
  input  logic [CNT_W-1:0] cfg_frames,
  input  logic [CNT_W-1:0] cfg_reload,
  input  logic             cfg_frame_sync,
  input  logic             fire,
  output logic [CNT_W-1:0] bytes,
  output sync_mode_e       mode,
  output logic             frame_end,
  output logic             event_end,
  output logic             final_req,
  output logic             live,
  output logic             live_nxt
);

  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] bytes_q, bytes_n;
  logic [CNT_W-1:0] arrs_q,  arrs_n;
  logic [CNT_W-1:0] rld_q,   rld_n;
  logic [CNT_W-1:0] left_q,  left_n;
  logic [CNT_W-1:0] frm_q,   frm_n;
  sync_mode_e       mode_q,  mode_n;
  logic             cfg_ok;
  logic             en;

  assign cfg_ok = (cfg_bytes != ZERO) && (cfg_arrays != ZERO) && (cfg_frames != ZERO)
               && !(!cfg_frame_sync && (cfg_frames > ONE) && (cfg_reload == ZERO));

  assign frame_end = (left_q == ONE);
  assign event_end = (mode_q == SYNC_FRAME) ? frame_end : 1'b1;
  assign final_req = frame_end && (frm_q == ONE);
  assign en        = load || fire;

  always_comb begin
    bytes_n = bytes_q;
    arrs_n  = arrs_q;
    rld_n   = rld_q;
    left_n  = left_q;
    frm_n   = frm_q;
    mode_n  = mode_q;
    if (load) begin
      bytes_n = cfg_bytes;
      arrs_n  = cfg_arrays;
      rld_n   = cfg_reload;
      left_n  = cfg_arrays;
      frm_n   = cfg_ok ? cfg_frames : ZERO;
      mode_n  = sync_mode_e'(cfg_frame_sync);
    end else if (fire) begin
      if (frame_end) begin
        frm_n  = frm_q - ONE;
        left_n = (mode_q == SYNC_FRAME) ? arrs_q : rld_q;
      end else begin
        left_n = left_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bytes_q <= ZERO;
      arrs_q  <= ZERO;
      rld_q   <= ZERO;
      left_q  <= ZERO;
      frm_q   <= ZERO;
      mode_q  <= SYNC_ARRAY;
    end else if (en) begin
      bytes_q <= bytes_n;
      arrs_q  <= arrs_n;
      rld_q   <= rld_n;
      left_q  <= left_n;
      frm_q   <= frm_n;
      mode_q  <= mode_n;
    end
  end

  assign bytes    = bytes_q;
  assign mode     = mode_q;
  assign live     = (frm_q != ZERO);
  assign live_nxt = (frm_n != ZERO);

endmodule

// File: rtl/dma3d_ptr.sv
// One address lane: current array pointer plus frame start pointer.
module dma3d_ptr #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              fire,
  input  logic              frame_end,
  input  logic              frame_sync,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W-1:0]  cfg_aidx,
  input  logic [IDX_W-1:0]  cfg_fidx,
  output logic [ADDR_W-1:0] cur
);

  localparam int EXT_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] arr_q, arr_n;
  logic [ADDR_W-1:0] frm_q, frm_n;
  logic [IDX_W-1:0]  aidx_q, aidx_n;
  logic [IDX_W-1:0]  fidx_q, fidx_n;
  logic [ADDR_W-1:0] aidx_ext, fidx_ext;
  logic [ADDR_W-1:0] jump_from, jump_to;
  logic              en;

  assign aidx_ext  = {{EXT_W{aidx_q[IDX_W-1]}}, aidx_q};
  assign fidx_ext  = {{EXT_W{fidx_q[IDX_W-1]}}, fidx_q};
  assign jump_from = frame_sync ? frm_q : arr_q;
  assign jump_to   = jump_from + fidx_ext;
  assign en        = load || fire;

  always_comb begin
    arr_n  = arr_q;
    frm_n  = frm_q;
    aidx_n = aidx_q;
    fidx_n = fidx_q;
    if (load) begin
      arr_n  = cfg_base;
      frm_n  = cfg_base;
      aidx_n = cfg_aidx;
      fidx_n = cfg_fidx;
    end else if (fire) begin
      if (frame_end) begin
        arr_n = jump_to;
        frm_n = jump_to;
      end else begin
        arr_n = arr_q + aidx_ext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_q  <= '0;
      frm_q  <= '0;
      aidx_q <= '0;
      fidx_q <= '0;
    end else if (en) begin
      arr_q  <= arr_n;
      frm_q  <= frm_n;
      aidx_q <= aidx_n;
      fidx_q <= fidx_n;
    end
  end

  assign cur = arr_q;

endmodule

// File: rtl/dma3d_seq.sv
// Three-dimensional transfer sequencer top.
module dma3d_seq
  import dma3d_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int IDX_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic [ADDR_W-1:0]    cfg_src,
  input  logic [ADDR_W-1:0]    cfg_dst,
  input  logic [2*CNT_W-1:0]   cfg_count_word,
  input  logic [CNT_W-1:0]     cfg_frames,
  input  logic [IDX_W-1:0]     cfg_src_aidx,
  input  logic [IDX_W-1:0]     cfg_dst_aidx,
  input  logic [IDX_W-1:0]     cfg_src_fidx,
  input  logic [IDX_W-1:0]     cfg_dst_fidx,
  input  logic [CNT_W-1:0]     cfg_arr_reload,
  input  logic                 cfg_frame_sync,
  input  logic                 sync_evt,
  input  logic                 req_ready,
  output logic                 req_valid,
  output logic [ADDR_W-1:0]    req_src,
  output logic [ADDR_W-1:0]    req_dst,
  output logic [CNT_W-1:0]     req_bytes,
  output logic                 set_active,
  output logic                 set_done,
  output logic                 evt_missed
);

  logic             busy_q, busy_n;
  logic             done_q, done_n;
  logic             fire, serve_end, start;
  logic             frame_end, event_end, final_req, live, live_nxt;
  logic             frame_sync;
  sync_mode_e       mode;
  logic [ADDR_W-1:0] base_v [NUM_PTR];
  logic [IDX_W-1:0]  aidx_v [NUM_PTR];
  logic [IDX_W-1:0]  fidx_v [NUM_PTR];
  logic [ADDR_W-1:0] cur_v  [NUM_PTR];

  assign fire       = busy_q && req_ready;
  assign serve_end  = fire && event_end;
  assign frame_sync = (mode == SYNC_FRAME);

  dma3d_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (cfg_load),
    .cfg_arrays     (cfg_count_word[2*CNT_W-1:CNT_W]),
    .cfg_bytes      (cfg_count_word[CNT_W-1:0]),
    .cfg_frames     (cfg_frames),
    .cfg_reload     (cfg_arr_reload),
    .cfg_frame_sync (cfg_frame_sync),
    .fire           (fire),
    .bytes          (req_bytes),
    .mode           (mode),
    .frame_end      (frame_end),
    .event_end      (event_end),
    .final_req      (final_req),
    .live           (live),
    .live_nxt       (live_nxt)
  );

  dma3d_evq u_evq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .evt       (sync_evt),
    .busy      (busy_q),
    .serve_end (serve_end),
    .live_nxt  (live_nxt),
    .start     (start),
    .missed    (evt_missed)
  );

  assign base_v[PTR_SRC] = cfg_src;
  assign base_v[PTR_DST] = cfg_dst;
  assign aidx_v[PTR_SRC] = cfg_src_aidx;
  assign aidx_v[PTR_DST] = cfg_dst_aidx;
  assign fidx_v[PTR_SRC] = cfg_src_fidx;
  assign fidx_v[PTR_DST] = cfg_dst_fidx;

  for (genvar c = 0; c < NUM_PTR; c++) begin : g_ptr
    dma3d_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cfg_load),
      .fire       (fire),
      .frame_end  (frame_end),
      .frame_sync (frame_sync),
      .cfg_base   (base_v[c]),
      .cfg_aidx   (aidx_v[c]),
      .cfg_fidx   (fidx_v[c]),
      .cur        (cur_v[c])
    );
  end

  always_comb begin
    if (cfg_load) begin
      busy_n = 1'b0;
      done_n = 1'b0;
    end else begin
      busy_n = (busy_q && !serve_end) || start;
      done_n = fire && final_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      done_q <= done_n;
    end
  end

  assign req_valid  = busy_q;
  assign req_src    = cur_v[PTR_SRC];
  assign req_dst    = cur_v[PTR_DST];
  assign set_active = live;
  assign set_done   = done_q;

endmodule

// File: rtl/dma3d_seq_chk.sv
// Port-level properties of the sequencer, bound to the top.
module dma3d_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              sync_evt,
  input logic              req_ready,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_src,
  input logic [ADDR_W-1:0] req_dst,
  input logic [CNT_W-1:0]  req_bytes,
  input logic              set_active,
  input logic              set_done,
  input logic              evt_missed
);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !cfg_load) |=>
      (req_valid && $stable(req_src) && $stable(req_dst) && $stable(req_bytes)));

  // R10
  no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_active |-> !req_valid);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> !set_done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |-> (!set_active && !req_valid));

  // R9
  miss_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_missed |-> $past(sync_evt || req_valid));

  // R2
  bytes_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_bytes != '0));

endmodule

bind dma3d_seq dma3d_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_load   (cfg_load),
  .sync_evt   (sync_evt),
  .req_ready  (req_ready),
  .req_valid  (req_valid),
  .req_src    (req_src),
  .req_dst    (req_dst),
  .req_bytes  (req_bytes),
  .set_active (set_active),
  .set_done   (set_done),
  .evt_missed (evt_missed)
);

// File: tb/dma3d_seq_tb.sv
`timescale 1ns/1ps
module dma3d_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [31:0] cfg_src = '0, cfg_dst = '0, cfg_count_word = '0;
  logic [15:0] cfg_frames = '0, cfg_src_aidx = '0, cfg_dst_aidx = '0;
  logic [15:0] cfg_src_fidx = '0, cfg_dst_fidx = '0, cfg_arr_reload = '0;
  logic        cfg_frame_sync = 1'b0;
  logic        sync_evt = 1'b0;
  logic        req_ready = 1'b0;
  logic        req_valid;
  logic [31:0] req_src, req_dst;
  logic [15:0] req_bytes;
  logic        set_active, set_done, evt_missed;

  always #2.5 clk = ~clk;

  dma3d_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src), .cfg_dst(cfg_dst),
    .cfg_count_word(cfg_count_word), .cfg_frames(cfg_frames),
    .cfg_src_aidx(cfg_src_aidx), .cfg_dst_aidx(cfg_dst_aidx),
    .cfg_src_fidx(cfg_src_fidx), .cfg_dst_fidx(cfg_dst_fidx),
    .cfg_arr_reload(cfg_arr_reload), .cfg_frame_sync(cfg_frame_sync),
    .sync_evt(sync_evt), .req_ready(req_ready), .req_valid(req_valid),
    .req_src(req_src), .req_dst(req_dst), .req_bytes(req_bytes),
    .set_active(set_active), .set_done(set_done), .evt_missed(evt_missed)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // ---------------- reference model ----------------
  typedef struct { logic [31:0] s; logic [31:0] d; bit ev_last; bit fin; } ent_t;
  ent_t mq[$];
  bit   m_busy, m_pend, m_done, m_miss;
  logic [15:0] m_bytes;

  task automatic build();
    int a, b, c, r, n;
    logic [31:0] s, d, fs, fd;
    bit ok;
    a = int'(cfg_count_word[15:0]);
    b = int'(cfg_count_word[31:16]);
    c = int'(cfg_frames);
    r = int'(cfg_arr_reload);
    ok = (a != 0) && (b != 0) && (c != 0) && !(!cfg_frame_sync && c > 1 && r == 0);
    mq.delete();
    m_bytes = cfg_count_word[15:0];
    if (!ok) return;
    s = cfg_src; d = cfg_dst;
    for (int f = 0; f < c; f++) begin
      n = (cfg_frame_sync || f == 0) ? b : r;
      fs = s; fd = d;
      for (int k = 0; k < n; k++) begin
        mq.push_back('{s, d, (cfg_frame_sync ? (k == n - 1) : 1'b1), (f == c - 1 && k == n - 1)});
        if (k < n - 1) begin
          s = s + 32'(int'($signed(cfg_src_aidx)));
          d = d + 32'(int'($signed(cfg_dst_aidx)));
        end else if (cfg_frame_sync) begin
          s = fs + 32'(int'($signed(cfg_src_fidx)));
          d = fd + 32'(int'($signed(cfg_dst_fidx)));
        end else begin
          s = s + 32'(int'($signed(cfg_src_fidx)));
          d = d + 32'(int'($signed(cfg_dst_fidx)));
        end
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    ent_t e;
    bit send, live, sfree, st;
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_done = 0; m_miss = 0; mq.delete();
    end else begin
      m_done = 0; m_miss = 0;
      if (cfg_load) begin
        build();
        m_busy = 0; m_pend = 0; m_miss = sync_evt;
      end else begin
        send = 0; st = 0;
        if (m_busy && req_ready) begin
          e = mq.pop_front();
          send = e.ev_last;
          m_done = e.fin;
        end
        live  = (mq.size() != 0);
        sfree = !m_busy || send;
        if (!live) begin
          m_miss = sync_evt || m_pend; m_pend = 0;
        end else if (sfree) begin
          if (m_pend) begin st = 1; m_pend = sync_evt; end
          else if (sync_evt) st = 1;
        end else if (sync_evt) begin
          if (m_pend) m_miss = 1; else m_pend = 1;
        end
        m_busy = (m_busy && !send) || st;
      end
    end
  end

  // ---------------- per-cycle compare and statistics ----------------
  int n_fire, n_miss, n_done, tot_bytes;
  logic [31:0] fsrc[$], fdst[$];
  bit   p_stall;
  logic [31:0] p_src, p_dst;
  logic [15:0] p_bytes;

  task automatic clear_stats();
    n_fire = 0; n_miss = 0; n_done = 0; tot_bytes = 0;
    fsrc.delete(); fdst.delete();
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      report();
    end
    if (rst_n) begin
      chk(req_valid === m_busy, "R9 req_valid", req_valid, m_busy);
      if (m_busy && mq.size() != 0) begin
        chk(req_src === mq[0].s, "R6 req_src", req_src, mq[0].s);
        chk(req_dst === mq[0].d, "R6 req_dst", req_dst, mq[0].d);
        chk(req_bytes === m_bytes, "R2 req_bytes", req_bytes, m_bytes);
      end
      chk(set_done === m_done, "R8 set_done", set_done, m_done);
      chk(evt_missed === m_miss, "R10 evt_missed", evt_missed, m_miss);
      chk(set_active === (mq.size() != 0), "R11 set_active", set_active, mq.size() != 0);
      if (p_stall)  // R12
        chk(req_valid && req_src == p_src && req_dst == p_dst && req_bytes == p_bytes,
            "R12 held request", req_src, p_src);
      p_stall = req_valid && !req_ready && !cfg_load;
      p_src = req_src; p_dst = req_dst; p_bytes = req_bytes;
      if (req_valid && req_ready) begin
        n_fire++; tot_bytes += int'(req_bytes);
        fsrc.push_back(req_src); fdst.push_back(req_dst);
      end
      n_miss += int'(evt_missed);
      n_done += int'(set_done);
    end
  end

  // ---------------- stimulus ----------------
  int rdy_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic tick(bit e);
    @(posedge clk); #1;
    cfg_load = 0;
    sync_evt = e;
    req_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic load_set(logic [31:0] s, logic [31:0] d, logic [15:0] arrs, logic [15:0] bts,
                          logic [15:0] frm, logic [15:0] sa, logic [15:0] da,
                          logic [15:0] sf, logic [15:0] df, logic [15:0] rld, bit fsync);
    @(posedge clk); #1;
    cfg_src = s; cfg_dst = d; cfg_count_word = {arrs, bts}; cfg_frames = frm;
    cfg_src_aidx = sa; cfg_dst_aidx = da; cfg_src_fidx = sf; cfg_dst_fidx = df;
    cfg_arr_reload = rld; cfg_frame_sync = fsync;
    cfg_load = 1; sync_evt = 0;
    tick(0);
  endtask

  task automatic drain();
    int guard = 0;
    do begin tick(0); guard++; end while ((m_busy || m_pend) && guard < 2000);
    tick(0);
  endtask

  task automatic events(int n);
    for (int i = 0; i < n; i++) begin tick(1); drain(); end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R1
    chk(!req_valid && !set_active && !set_done && !evt_missed, "R1 reset state",
        {req_valid, set_active, set_done, evt_missed}, 0);

    // R10: event before any load
    clear_stats(); events(1);
    chk(n_miss == 1 && n_fire == 0, "R10 event with no set", n_miss, 1);

    // array-synchronized set: 3 arrays of 4 bytes, 2 frames, reload 2
    rdy_mode = 1;
    load_set(32'h1000, 32'h2000, 16'd3, 16'd4, 16'd2, 16'd16, 16'd8, 16'hFFFC, 16'd100, 16'd2, 1'b0);
    clear_stats(); events(1);
    chk(n_fire == 1, "R3 one array per event", n_fire, 1);
    events(4);
    chk(n_fire == 5, "R4 arrays plus reload arrays", n_fire, 5);
    chk(fsrc[1] == 32'h1010 && fdst[1] == 32'h2008, "R6 array stride", fsrc[1], 32'h1010);
    chk(fsrc[3] == 32'h101C, "R7 array-mode source frame stride", fsrc[3], 32'h101C);
    chk(fdst[3] == 32'h2074, "R7 array-mode destination frame stride", fdst[3], 32'h2074);
    chk(fsrc[4] == 32'h102C, "R4 reloaded frame continues", fsrc[4], 32'h102C);
    chk(n_done == 1 && !set_active, "R8 completion", n_done, 1);
    clear_stats(); events(1);
    chk(n_miss == 1 && n_fire == 0, "R10 event after completion", n_miss, 1);

    // frame-synchronized set: 3 arrays of 8 bytes, 2 frames, reload 0 ignored
    load_set(32'h3000, 32'h4000, 16'd3, 16'd8, 16'd2, 16'hFFE0, 16'd4, 16'h0200, 16'hFF00, 16'd0, 1'b1);
    chk(set_active, "R5 zero reload accepted in frame mode", set_active, 1);
    clear_stats(); events(1);
    chk(n_fire == 3, "R5 whole frame per event", n_fire, 3);
    events(1);
    chk(tot_bytes == 48, "R2 total bytes", tot_bytes, 48);
    chk(fdst[2] == 32'h4008 && fsrc[2] == 32'h2FC0, "R6 signed array stride", fsrc[2], 32'h2FC0);
    chk(fsrc[3] == 32'h3200, "R7 frame-mode source frame stride", fsrc[3], 32'h3200);
    chk(fdst[3] == 32'h3F00, "R7 frame-mode destination frame stride", fdst[3], 32'h3F00);
    chk(n_done == 1, "R8 frame-mode completion", n_done, 1);

    // R9: burst under backpressure
    load_set(32'h100, 32'h200, 16'd4, 16'd2, 16'd1, 16'd1, 16'd1, 16'd0, 16'd0, 16'd0, 1'b0);
    clear_stats();
    rdy_mode = 2;
    tick(1); tick(1); tick(1); tick(0); tick(0);
    rdy_mode = 0;
    drain();
    chk(n_miss == 1, "R9 third event missed", n_miss, 1);
    chk(n_fire == 2, "R9 held event served", n_fire, 2);
    events(2);
    chk(n_done == 1, "R9 set completes", n_done, 1);

    // R9: held event dropped when the set completes
    load_set(32'h500, 32'h600, 16'd2, 16'd1, 16'd1, 16'd1, 16'd1, 16'd0, 16'd0, 16'd0, 1'b1);
    clear_stats();
    tick(1); tick(1); drain();
    chk(n_fire == 2 && n_done == 1, "R9 frame served", n_fire, 2);
    chk(n_miss == 1, "R9 held event dropped at completion", n_miss, 1);

    // R11: rejected loads
    load_set(32'h0, 32'h0, 16'd2, 16'd0, 16'd1, 16'd0, 16'd0, 16'd0, 16'd0, 16'd1, 1'b0);
    chk(!set_active, "R11 zero byte count", set_active, 0);
    load_set(32'h0, 32'h0, 16'd2, 16'd4, 16'd2, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0);
    chk(!set_active, "R11 zero reload with several frames", set_active, 0);
    clear_stats(); events(1);
    chk(n_miss == 1 && n_fire == 0, "R10 event on rejected set", n_miss, 1);

    repeat (4) tick(0);
    report();
  end

endmodule